// File: doc/BRIEF.md
# Transactional Cache with Commit and Abort

This block is a small, fully associative store that holds the tentative data of one processor's memory transaction. Each slot carries an address tag, one data word, a written bit and one of four transactional states: INVALID, NORMAL, COMMIT (the pre-transaction copy) or ABORT (the tentative copy). The processor issues transactional loads, exclusive loads and stores. A line that the transaction touches is held as a pair: an ABORT slot that takes the new data and a COMMIT slot that keeps the old data. COMMIT, ABORT and VALIDATE requests end or query the transaction. Ending a transaction retags every slot in a single cycle.

Lines that are not present are fetched through a plain request/response memory port. A memory reply may be a BUSY refusal, and a BUSY reply kills the transaction. A combinational snoop port answers other processors' reads. It returns data, reports a miss, or replies BUSY when the remote access conflicts with a line that this transaction has written. Two flags are visible at the ports. `tx_active` shows that a transaction is in progress. `tx_status` shows that the transaction is still valid, as opposed to doomed.

The control has two states. **IDLE** accepts a request and either answers it in the next cycle or, on a miss, moves to **FETCH**. **FETCH** holds `mem_req` until a memory reply arrives, installs the slot pair or aborts, and then returns to IDLE. The named transitions are IDLE→IDLE (hit or control request), IDLE→FETCH (transactional miss) and FETCH→IDLE (memory reply).

Top module: `txn_cache`

## Requirements
- R1: After reset, `tx_active` is 0, `tx_status` is 1, `req_ready` is 1, `rsp_valid` is 0, and no snoop hits.
- R2: A transactional access misses when no slot holds its address. The access codes are 0 (load), 1 (exclusive load) and 2 (store). On a miss the block reads memory and installs an ABORT slot and a COMMIT slot, both filled with the returned word. A store then overwrites the ABORT slot with its write data. The reply has `rsp_ok`=1 and carries the ABORT slot's data. The first access of a transaction sets `tx_active` and `tx_status`.
- R3: An access that hits an ABORT slot is answered from that slot without a memory read. A store writes its data into that slot.
- R4: An access that hits a NORMAL slot retags that slot to ABORT and copies its data into a newly chosen slot in COMMIT state, without a memory read.
- R5: When a new slot is needed, an INVALID slot is taken first, then a NORMAL slot, then a COMMIT slot, with the lowest index winning within a class. An ABORT slot is never taken. If too few slots are available, the transaction is aborted as in R6 and the reply has `rsp_ok`=0.
- R6: A BUSY memory reply aborts the transaction. `tx_status` goes to 0, ABORT slots become INVALID, COMMIT slots become NORMAL, and the reply has `rsp_ok`=0.
- R7: COMMIT (code 3) with `tx_status`=1 turns every COMMIT slot INVALID and every ABORT slot NORMAL in one cycle, replies `rsp_ok`=1 and clears `tx_active`.
- R8: ABORT (code 4), and COMMIT with `tx_status`=0, turn every ABORT slot INVALID and every COMMIT slot NORMAL in one cycle. ABORT replies `rsp_ok`=1; a failed COMMIT replies `rsp_ok`=0. Afterwards `tx_active` is 0 and `tx_status` is 1.
- R9: VALIDATE (code 5, and codes 6 and 7) replies `rsp_ok`=`tx_status` and changes nothing. A transactional access made while `tx_status`=0 replies `rsp_ok`=0 without a memory read.
- R10: When the snoop is non-transactional, or no valid transaction is live, only NORMAL slots answer a snoop.
- R11: For a transactional snoop while a valid transaction is live, a NORMAL or unwritten ABORT line returns its data. A written ABORT line returns BUSY. Stores and exclusive loads set the written bit.
- R12: A hit or a control request is answered in the cycle after it is accepted. A miss is answered in the cycle after `mem_rsp_valid`. `req_ready` is high only in IDLE, and `mem_req` is held until the memory reply arrives.
- R13: A snoop in the same cycle as a COMMIT or ABORT retag is answered from the slot states before the retag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Request accepted this cycle (IDLE) |
| req_op | input | 3 | 0 load, 1 exclusive load, 2 store, 3 commit, 4 abort, 5 validate |
| req_addr | input | AW | Word address of the access |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Access or commit succeeded / validate result |
| rsp_data | output | DW | Load result or stored word |
| mem_req | output | 1 | Memory read request, held while waiting |
| mem_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory reply strobe |
| mem_rsp_busy | input | 1 | Memory reply is a BUSY refusal |
| mem_rsp_data | input | DW | Memory read data |
| snp_valid | input | 1 | Remote read present |
| snp_txn | input | 1 | Remote read is transactional |
| snp_addr | input | AW | Remote read address |
| snp_hit | output | 1 | Snoop supplies data |
| snp_busy | output | 1 | Snoop conflicts, reply BUSY |
| snp_data | output | DW | Snoop data |
| tx_active | output | 1 | A transaction is in progress |
| tx_status | output | 1 | The transaction is still valid |

## Verification
A remote snoop and the bulk retag of a COMMIT or ABORT request can fall in the same cycle. The snoop reply is combinational, while the retag takes effect only at the clock edge. The bench provokes this by presenting a COMMIT and a transactional snoop of a written line at the same moment. It expects BUSY before the edge and clean data from the now NORMAL line after it. A BUSY memory reply that lands while an ABORT/COMMIT pair is already held is also checked, by observing the restored line through a non-transactional snoop.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        TS_INVALID = 2'd0,
        TS_NORMAL  = 2'd1,
        TS_COMMIT  = 2'd2,
        TS_ABORT   = 2'd3
    } tstate_e;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_LOADX    = 3'd1,
        OP_STORE    = 3'd2,
        OP_COMMIT   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_VALIDATE = 3'd5
    } op_e;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FETCH = 1'b1
    } fsm_e;

    // Successful end: old copies vanish, tentative copies become the line.
    function automatic tstate_e retag_seal(tstate_e s);
        case (s)
            TS_COMMIT: return TS_INVALID;
            TS_ABORT:  return TS_NORMAL;
            default:   return s;
        endcase
    endfunction

    // Failed end: tentative copies vanish, old copies become the line.
    function automatic tstate_e retag_drop(tstate_e s);
        case (s)
            TS_ABORT:  return TS_INVALID;
            TS_COMMIT: return TS_NORMAL;
            default:   return s;
        endcase
    endfunction

endpackage

// File: rtl/txc_slot_pick.sv
module txc_slot_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  inv_m,
    input  logic [N-1:0]  nrm_m,
    input  logic [N-1:0]  cmt_m,
    input  logic [N-1:0]  excl_m,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] c_inv, c_nrm, c_cmt, tier;

    always_comb begin
        c_inv = inv_m & ~excl_m;
        c_nrm = nrm_m & ~excl_m;
        c_cmt = cmt_m & ~excl_m;
        if (|c_inv)      tier = c_inv;
        else if (|c_nrm) tier = c_nrm;
        else             tier = c_cmt;
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (tier[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/txc_snoop.sv
module txc_snoop #(
    parameter int N  = 4,
    parameter int DW = 16
) (
    input  logic [N-1:0]    match_m,
    input  logic [N-1:0]    nrm_m,
    input  logic [N-1:0]    abt_m,
    input  logic [N-1:0]    wr_m,
    input  logic            live,
    input  logic [N*DW-1:0] dat_flat,
    output logic            hit,
    output logic            busy,
    output logic [DW-1:0]   data
);
    logic [N-1:0] resp_m;

    always_comb begin
        resp_m = match_m & (nrm_m | (live ? (abt_m & ~wr_m) : '0));
        busy   = live & (|(match_m & abt_m & wr_m));
        hit    = (|resp_m) & ~busy;
        data   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (resp_m[i]) data = dat_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/txn_cache.sv
module txn_cache
    import txc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_busy,
    input  logic [DW-1:0] mem_rsp_data,
    input  logic          snp_valid,
    input  logic          snp_txn,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit,
    output logic          snp_busy,
    output logic [DW-1:0] snp_data,
    output logic          tx_active,
    output logic          tx_status
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    fsm_e          fsm_q, fsm_d;
    tstate_e       st_q  [ENTRIES];
    tstate_e       st_d  [ENTRIES];
    logic [AW-1:0] tag_q [ENTRIES];
    logic [AW-1:0] tag_d [ENTRIES];
    logic [DW-1:0] dat_q [ENTRIES];
    logic [DW-1:0] dat_d [ENTRIES];
    logic          wr_q  [ENTRIES];
    logic          wr_d  [ENTRIES];
    logic          act_q, act_d, stat_q, stat_d;
    op_e           pop_q, pop_d;
    logic [AW-1:0] pad_q, pad_d;
    logic [DW-1:0] pwd_q, pwd_d;
    logic          rv_q, rv_d, rok_q, rok_d;
    logic [DW-1:0] rdat_q, rdat_d;

    logic [ENTRIES-1:0]    inv_m, nrm_m, cmt_m, abt_m, wr_m, hit_m, snp_m;
    logic [ENTRIES*DW-1:0] dat_flat;
    logic [AW-1:0]         look_addr;
    op_e                   op_in;

    assign op_in     = op_e'(req_op);
    assign look_addr = (fsm_q == FS_FETCH) ? pad_q : req_addr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign inv_m[g] = (st_q[g] == TS_INVALID);
        assign nrm_m[g] = (st_q[g] == TS_NORMAL);
        assign cmt_m[g] = (st_q[g] == TS_COMMIT);
        assign abt_m[g] = (st_q[g] == TS_ABORT);
        assign wr_m[g]  = wr_q[g];
        assign hit_m[g] = (st_q[g] != TS_INVALID) && (tag_q[g] == look_addr);
        assign snp_m[g] = snp_valid && (st_q[g] != TS_INVALID) && (tag_q[g] == snp_addr);
        assign dat_flat[g*DW +: DW] = dat_q[g];
    end

    // Lookup: index of the ABORT and NORMAL copies of the addressed line.
    logic          any_abt, any_nrm;
    logic [IW-1:0] abt_idx, nrm_idx;
    always_comb begin
        any_abt = |(hit_m & abt_m);
        any_nrm = |(hit_m & nrm_m);
        abt_idx = '0;
        nrm_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_m[i] && abt_m[i]) abt_idx = IW'(i);
            if (hit_m[i] && nrm_m[i]) nrm_idx = IW'(i);
        end
    end

    // Two victim choices: the second never repeats the first.
    logic [ENTRIES-1:0] excl1, excl2;
    logic               found1, found2;
    logic [IW-1:0]      idx1, idx2;
    assign excl1 = hit_m & nrm_m;
    assign excl2 = excl1 | (found1 ? ({{(ENTRIES-1){1'b0}}, 1'b1} << idx1) : '0);

    txc_slot_pick #(.N(ENTRIES), .IW(IW)) u_pick1 (
        .inv_m(inv_m), .nrm_m(nrm_m), .cmt_m(cmt_m), .excl_m(excl1),
        .found(found1), .idx(idx1)
    );
    txc_slot_pick #(.N(ENTRIES), .IW(IW)) u_pick2 (
        .inv_m(inv_m), .nrm_m(nrm_m), .cmt_m(cmt_m), .excl_m(excl2),
        .found(found2), .idx(idx2)
    );

    txc_snoop #(.N(ENTRIES), .DW(DW)) u_snoop (
        .match_m(snp_m), .nrm_m(nrm_m), .abt_m(abt_m), .wr_m(wr_m),
        .live(act_q && stat_q && snp_txn), .dat_flat(dat_flat),
        .hit(snp_hit), .busy(snp_busy), .data(snp_data)
    );

    // Next-state and response logic.
    logic          drop, seal, tent_en;
    logic [IW-1:0] tent_idx;
    op_e           tent_op;
    logic [DW-1:0] tent_wd;

    always_comb begin
        fsm_d = fsm_q;  st_d = st_q;  tag_d = tag_q;  dat_d = dat_q;  wr_d = wr_q;
        act_d = act_q;  stat_d = stat_q;
        pop_d = pop_q;  pad_d = pad_q;  pwd_d = pwd_q;
        rv_d = 1'b0;  rok_d = 1'b0;  rdat_d = '0;
        drop = 1'b0;  seal = 1'b0;
        tent_en = 1'b0;  tent_idx = '0;  tent_op = op_in;  tent_wd = req_wdata;
        unique case (fsm_q)
            FS_IDLE: if (req_valid) begin
                unique case (op_in)
                    OP_LOAD, OP_LOADX, OP_STORE: begin
                        if (act_q && !stat_q) begin
                            rv_d = 1'b1;
                        end else begin
                            act_d  = 1'b1;
                            stat_d = 1'b1;
                            if (any_abt) begin
                                tent_en = 1'b1;  tent_idx = abt_idx;
                                rv_d = 1'b1;     rok_d = 1'b1;
                            end else if (any_nrm) begin
                                rv_d = 1'b1;
                                if (found1) begin
                                    st_d[nrm_idx] = TS_ABORT;
                                    st_d[idx1]    = TS_COMMIT;
                                    tag_d[idx1]   = req_addr;
                                    dat_d[idx1]   = dat_q[nrm_idx];
                                    wr_d[idx1]    = 1'b0;
                                    tent_en = 1'b1;  tent_idx = nrm_idx;
                                    rok_d = 1'b1;
                                end else begin
                                    drop = 1'b1;  stat_d = 1'b0;
                                end
                            end else begin
                                fsm_d = FS_FETCH;
                                pop_d = op_in;  pad_d = req_addr;  pwd_d = req_wdata;
                            end
                        end
                    end
                    OP_COMMIT: begin
                        seal  = stat_q;   drop  = !stat_q;
                        rv_d  = 1'b1;     rok_d = stat_q;
                        act_d = 1'b0;     stat_d = 1'b1;
                    end
                    OP_ABORT: begin
                        drop  = 1'b1;
                        rv_d  = 1'b1;     rok_d = 1'b1;
                        act_d = 1'b0;     stat_d = 1'b1;
                    end
                    default: begin
                        rv_d  = 1'b1;     rok_d = stat_q;
                    end
                endcase
            end
            FS_FETCH: if (mem_rsp_valid) begin
                fsm_d = FS_IDLE;
                rv_d  = 1'b1;
                if (mem_rsp_busy || !(found1 && found2)) begin
                    drop = 1'b1;  stat_d = 1'b0;
                end else begin
                    st_d[idx1] = TS_ABORT;   tag_d[idx1] = pad_q;
                    dat_d[idx1] = mem_rsp_data;  wr_d[idx1] = 1'b0;
                    st_d[idx2] = TS_COMMIT;  tag_d[idx2] = pad_q;
                    dat_d[idx2] = mem_rsp_data;  wr_d[idx2] = 1'b0;
                    tent_en = 1'b1;  tent_idx = idx1;
                    tent_op = pop_q; tent_wd = pwd_q;
                    rok_d = 1'b1;
                end
            end
            default: ;
        endcase

        if (tent_en) begin
            if (tent_op == OP_STORE) begin
                dat_d[tent_idx] = tent_wd;
                wr_d[tent_idx]  = 1'b1;
            end else if (tent_op == OP_LOADX) begin
                wr_d[tent_idx]  = 1'b1;
            end
            rdat_d = dat_d[tent_idx];
        end

        for (int i = 0; i < ENTRIES; i++) begin
            if (seal) st_d[i] = retag_seal(st_d[i]);
            if (drop) st_d[i] = retag_drop(st_d[i]);
            if (seal || drop) wr_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= FS_IDLE;
            act_q  <= 1'b0;
            stat_q <= 1'b1;
            pop_q  <= OP_LOAD;
            pad_q  <= '0;
            pwd_q  <= '0;
            rv_q   <= 1'b0;
            rok_q  <= 1'b0;
            rdat_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]  <= TS_INVALID;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
                wr_q[i]  <= 1'b0;
            end
        end else begin
            fsm_q  <= fsm_d;
            act_q  <= act_d;
            stat_q <= stat_d;
            pop_q  <= pop_d;
            pad_q  <= pad_d;
            pwd_q  <= pwd_d;
            rv_q   <= rv_d;
            rok_q  <= rok_d;
            rdat_q <= rdat_d;
            st_q   <= st_d;
            tag_q  <= tag_d;
            dat_q  <= dat_d;
            wr_q   <= wr_d;
        end
    end

    assign req_ready = (fsm_q == FS_IDLE);
    assign mem_req   = (fsm_q == FS_FETCH);
    assign mem_addr  = pad_q;
    assign rsp_valid = rv_q;
    assign rsp_ok    = rok_q;
    assign rsp_data  = rdat_q;
    assign tx_active = act_q;
    assign tx_status = stat_q;

endmodule

// File: rtl/txc_checker.sv
module txc_checker
    import txc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_ok,
    input logic       mem_req,
    input logic       mem_rsp_valid,
    input logic       mem_rsp_busy,
    input logic       snp_txn,
    input logic       snp_hit,
    input logic       snp_busy,
    input logic       tx_active,
    input logic       tx_status
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> tx_status); // R8

    AST_CTRL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc && (req_op >= 3'(OP_COMMIT)) |=> rsp_valid); // R12

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rsp_valid |=> mem_req); // R12

    AST_NO_ACCEPT_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R12

    AST_SNOOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(snp_hit && snp_busy)); // R11

    AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (rst)
        snp_busy |-> (tx_active && tx_status && snp_txn)); // R10

    AST_MEM_BUSY_KILLS: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_rsp_valid && mem_rsp_busy |=> rsp_valid && !rsp_ok && !tx_status); // R6

    AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (rst)
        acc && (req_op == 3'(OP_COMMIT)) |=> !tx_active && tx_status && (rsp_ok == $past(tx_status))); // R7

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (rst)
        acc && (req_op == 3'(OP_ABORT)) |=> !tx_active && tx_status && rsp_ok); // R8

    AST_VALIDATE_ECHO: assert property (@(posedge clk) disable iff (rst)
        acc && (req_op == 3'(OP_VALIDATE)) |=> rsp_ok == $past(tx_status) && $stable(tx_status)); // R9
endmodule

bind txn_cache txc_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_busy(mem_rsp_busy), .snp_txn(snp_txn), .snp_hit(snp_hit), .snp_busy(snp_busy),
    .tx_active(tx_active), .tx_status(tx_status)
);

// File: tb/txn_cache_tb.sv
module txn_cache_tb;
    localparam logic [2:0] C_LD = 3'd0, C_LDX = 3'd1, C_ST = 3'd2,
                           C_CMT = 3'd3, C_ABT = 3'd4, C_VAL = 3'd5;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_ok;
    logic [15:0] rsp_data;
    logic        mem_req;
    logic [7:0]  mem_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_busy = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic        snp_valid = 1'b0, snp_txn = 1'b0;
    logic [7:0]  snp_addr = '0;
    logic        snp_hit, snp_busy;
    logic [15:0] snp_data;
    logic        tx_active, tx_status;

    int n_chk = 0, n_bad = 0, mem_cnt = 0, lat = 0;
    logic        got_ok;
    logic [15:0] got_data;
    logic        busy_en = 1'b0;
    logic [7:0]  busy_a = '0;

    txn_cache u_dut (.*);

    always #10 clk = ~clk;

    function automatic logic [15:0] memf(input logic [7:0] a);
        return 16'(a) * 16'd37 + 16'h0105;
    endfunction

    task automatic chk(input string what, input logic [31:0] actual, input logic [31:0] expect_v);
        n_chk++;
        if (actual !== expect_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, actual, expect_v);
        end
    endtask

    // Memory model: answers two cycles after mem_req rises.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_busy  = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    cnt = 0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_busy  = busy_en && (mem_addr == busy_a);
                    mem_rsp_data  = memf(mem_addr);
                    mem_cnt++;
                end
            end else cnt = 0;
        end
    end

    task automatic do_req(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        got_ok   = rsp_ok;
        got_data = rsp_data;
    endtask

    task automatic snoop(input logic [7:0] a, input logic txn);
        snp_valid = 1'b1; snp_addr = a; snp_txn = txn;
        #1;
    endtask

    task automatic snoop_end();
        snp_valid = 1'b0; snp_txn = 1'b0;
    endtask

    initial begin
        #(64'd20 * 150000);
        n_bad++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int m0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_active", tx_active, 0);
        chk("R1 tx_status", tx_status, 1);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        snoop(8'h10, 1'b0); chk("R1 snoop miss", snp_hit, 0); snoop_end();

        // R2 load miss
        m0 = mem_cnt;
        do_req(C_LD, 8'h10, 0);
        chk("R2 load miss ok", got_ok, 1);
        chk("R2 load miss data", got_data, memf(8'h10));
        chk("R2 memory read", mem_cnt - m0, 1);
        chk("R2 tx_active set", tx_active, 1);
        chk("R12 miss latency", lat, 3);
        snoop(8'h10, 1'b0); chk("R10 pair hidden from plain snoop", snp_hit, 0); snoop_end();
        snoop(8'h10, 1'b1);
        chk("R11 unwritten txn snoop hit", snp_hit, 1);
        chk("R11 unwritten txn snoop data", snp_data, memf(8'h10));
        chk("R11 unwritten not busy", snp_busy, 0);
        snoop_end();

        // R3 store and load on ABORT slot
        m0 = mem_cnt;
        do_req(C_ST, 8'h10, 16'hBEEF);
        chk("R3 store hit ok", got_ok, 1);
        chk("R12 hit latency", lat, 1);
        do_req(C_LD, 8'h10, 0);
        chk("R3 load sees store", got_data, 16'hBEEF);
        chk("R3 no memory read", mem_cnt - m0, 0);
        snoop(8'h10, 1'b1); chk("R11 written line busy", snp_busy, 1); chk("R11 busy no hit", snp_hit, 0); snoop_end();

        // R7 commit
        do_req(C_CMT, 0, 0);
        chk("R7 commit ok", got_ok, 1);
        chk("R7 active cleared", tx_active, 0);
        snoop(8'h10, 1'b0); chk("R7 new value normal", snp_hit, 1); chk("R7 data", snp_data, 16'hBEEF); snoop_end();

        // R4 hit NORMAL, then R8 abort restores old value
        m0 = mem_cnt;
        do_req(C_LD, 8'h10, 0);
        chk("R4 normal hit data", got_data, 16'hBEEF);
        chk("R4 no memory read", mem_cnt - m0, 0);
        snoop(8'h10, 1'b0); chk("R4 line retagged", snp_hit, 0); snoop_end();
        do_req(C_ST, 8'h10, 16'h1234);
        do_req(C_ABT, 0, 0);
        chk("R8 abort ok", got_ok, 1);
        chk("R8 status after abort", tx_status, 1);
        snoop(8'h10, 1'b0); chk("R8 old value back", snp_data, 16'hBEEF); chk("R8 hit", snp_hit, 1); snoop_end();

        // R5 slot priority
        do_req(C_LD, 8'h20, 0);
        do_req(C_LD, 8'h30, 0);
        snoop(8'h10, 1'b0); chk("R5 normal evicted after invalid", snp_hit, 0); snoop_end();
        do_req(C_LD, 8'h40, 0);
        chk("R5 commit slots reused", got_ok, 1);
        chk("R5 data", got_data, memf(8'h40));
        do_req(C_LD, 8'h50, 0);
        chk("R5 overflow fails", got_ok, 0);
        chk("R5 overflow status", tx_status, 0);
        do_req(C_VAL, 0, 0);
        chk("R9 validate reports abort", got_ok, 0);
        chk("R9 still active", tx_active, 1);
        snoop(8'h40, 1'b0); chk("R5 commit copy kept", snp_hit, 1); chk("R5 kept data", snp_data, memf(8'h40)); snoop_end();
        snoop(8'h20, 1'b0); chk("R5 evicted commit gone", snp_hit, 0); snoop_end();
        m0 = mem_cnt;
        do_req(C_LD, 8'h60, 0);
        chk("R9 doomed access fails", got_ok, 0);
        chk("R9 doomed no memory read", mem_cnt - m0, 0);
        do_req(C_CMT, 0, 0);
        chk("R8 failed commit", got_ok, 0);
        chk("R8 active after failed commit", tx_active, 0);
        chk("R8 status after failed commit", tx_status, 1);

        // R6 BUSY memory reply
        do_req(C_LD, 8'h60, 0);
        busy_en = 1'b1; busy_a = 8'h70;
        do_req(C_LD, 8'h70, 0);
        chk("R6 busy fails", got_ok, 0);
        chk("R6 status cleared", tx_status, 0);
        snoop(8'h60, 1'b0); chk("R6 commit copy normal", snp_hit, 1); chk("R6 data", snp_data, memf(8'h60)); snoop_end();
        do_req(C_ABT, 0, 0);
        busy_en = 1'b0;

        // R11 exclusive load marks written
        do_req(C_LDX, 8'h40, 0);
        chk("R11 ldx data", got_data, memf(8'h40));
        snoop(8'h40, 1'b1); chk("R11 ldx busy", snp_busy, 1); snoop_end();
        snoop(8'h60, 1'b1); chk("R11 normal serves txn snoop", snp_hit, 1); chk("R11 data", snp_data, memf(8'h60)); snoop_end();

        // R13 snoop in commit cycle
        @(negedge clk);
        req_valid = 1'b1; req_op = C_CMT;
        snoop(8'h40, 1'b1);
        chk("R13 busy before retag", snp_busy, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R13 hit after retag", snp_hit, 1);
        chk("R13 busy after retag", snp_busy, 0);
        chk("R13 data after retag", snp_data, memf(8'h40));
        chk("R7 commit response", rsp_valid && rsp_ok, 1);
        snoop_end();

        // Load sweep
        for (int k = 0; k < 8; k++) begin
            logic [7:0] a;
            a = 8'h80 + 8'(k);
            do_req(C_LD, a, 0);
            chk("R2 sweep load data", got_data, memf(a));
            snoop(a, 1'b1); chk("R11 sweep txn snoop", snp_data, memf(a)); snoop_end();
            do_req(C_CMT, 0, 0);
            chk("R7 sweep commit", got_ok, 1);
            snoop(a, 1'b0); chk("R7 sweep plain snoop", snp_data, memf(a)); snoop_end();
        end

        // Store-miss sweep
        for (int k = 0; k < 4; k++) begin
            logic [7:0] a;
            a = 8'hA0 + 8'(k);
            do_req(C_ST, a, 16'h5A00 + 16'(k));
            chk("R2 store miss data", got_data, 16'h5A00 + 16'(k));
            snoop(a, 1'b1); chk("R11 store miss busy", snp_busy, 1); snoop_end();
            do_req(C_ABT, 0, 0);
            snoop(a, 1'b0); chk("R8 store discarded", snp_data, memf(a)); snoop_end();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule